// File: doc/BRIEF.md
# Internal Bus Interface Unit

This unit sits between a processor core and the on-chip memory regions (program ROM, working RAM and the special-function register space). The core hands it one transfer at a time: an address, a direction flag and, for a write, one data byte. The unit holds these in its own address register and data buffer, decodes the region, drives the internal address and data buses for a fixed number of clocks, and stalls the core until the transfer is over. For a read, the byte coming back from the internal data bus is captured into the data buffer, and the core continues with it.

RAM and register-space transfers always last two clocks. ROM transfers last two or three clocks, chosen by a select bit that the unit keeps in a control register in the register space. Software sets the three-clock setting before the core reprograms its own flash, and clears it for normal running. The setting is read once, when a transfer is accepted, so a change never alters a transfer that is already under way.

The request side follows valid/ready rules. The core raises `cpu_req` with `cpu_we`, `cpu_addr` and `cpu_wdata` and keeps the request raised until `cpu_ready`. Back-pressure is the stall: `cpu_ready` stays low for as long as the bus cycle lasts. The unit samples the request fields only in the idle clock in which it accepts the request. A request still raised in the clock after `cpu_ready` counts as a new transfer.

Top module: `ibiu_top`

## Requirements
- R1: After reset, `cpu_ready`, `bus_we` and `bus_sel` are 0, and the ROM select bit is 0, so ROM transfers start at two clocks.
- R2: A transfer to RAM (0x0080 to 0x0FFF) or to the register space (0x0000 to 0x007F) makes `cpu_ready` rise exactly two clocks after the accepting edge, whatever the select bit holds.
- R3: A ROM transfer (0x8000 to 0xFFFF) lasts two clocks while the select bit is 0 and three clocks while it is 1.
- R4: The control register sits at 0x005F, and the select bit is its bit 7. A write there sets the bit from bit 7 of the data. A read returns the bit in bit 7 and zeros in every other bit. Neither access raises `bus_we` or any `bus_sel` line.
- R5: A new select bit value applies from the first transfer accepted after the control-register write completes.
- R6: On a read, `cpu_rdata` in the `cpu_ready` clock equals the internal data bus in that final clock. It keeps that value until the next read ends.
- R7: `bus_sel` is one-hot while a memory transfer runs (bit 0 ROM, bit 1 RAM, bit 2 register space) and zero otherwise. `bus_we` is high only in the final clock of a write. `bus_addr` and `bus_wdata` stay stable across the whole transfer.
- R8: An address outside every region completes in two clocks, reads as 0x00, raises no `bus_sel` line and never pulses `bus_we`, so memory is untouched.
- R9: `cpu_ready` is high for exactly one clock per transfer. While `cpu_req` is low, no transfer starts.
- R10: Changes to `cpu_addr`, `cpu_wdata` or `cpu_we` after the accepting edge do not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Transfer request (valid) |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Transfer address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-clock pulse in the final clock of a transfer |
| cpu_rdata | output | DATA_W | Read data (valid with cpu_ready, held afterwards) |
| bus_addr | output | ADDR_W | Internal address bus |
| bus_wdata | output | DATA_W | Internal write data bus |
| bus_we | output | 1 | Memory write strobe, final clock only |
| bus_sel | output | 3 | One-hot region select: ROM, RAM, register space |
| bus_rdata | input | DATA_W | Internal read data bus |

## Verification
Two functions meet at one clock boundary: a control-register write that changes the select bit completes, and the next ROM request is accepted in the idle clock that follows. The bench issues that ROM read directly after the write. The scoreboard then checks that the read takes the new length (three clocks, and later two again) while the control write itself kept its two-clock length. A second overlap, fields changed while a transfer is running, is provoked by scrambling the request fields one clock after acceptance. It is judged by the bus strobe contents and by later readback.

// File: rtl/ibiu_pkg.sv
package ibiu_pkg;

  // region codes double as the one-hot bus select pattern
  typedef enum logic [2:0] {
    RG_NONE = 3'b000,
    RG_ROM  = 3'b001,
    RG_RAM  = 3'b010,
    RG_SFR  = 3'b100
  } region_e;

  typedef struct packed {
    region_e region;
    logic    is_ctl;
  } decode_t;

endpackage

// File: rtl/ibiu_decode.sv
module ibiu_decode
  import ibiu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned SFR_BASE = 'h0000,
  parameter int unsigned SFR_SIZE = 'h0080,
  parameter int unsigned RAM_BASE = 'h0080,
  parameter int unsigned RAM_SIZE = 'h0F80,
  parameter int unsigned ROM_BASE = 'h8000,
  parameter int unsigned ROM_SIZE = 'h8000,
  parameter int unsigned CTL_ADDR = 'h005F
) (
  input  logic [ADDR_W-1:0] addr,
  output decode_t           dec
);

  localparam int unsigned W = ADDR_W + 1;
  localparam int unsigned SFR_END = SFR_BASE + SFR_SIZE;
  localparam int unsigned RAM_END = RAM_BASE + RAM_SIZE;
  localparam int unsigned ROM_END = ROM_BASE + ROM_SIZE;

  localparam logic [W-1:0] SFR_LO = SFR_BASE[W-1:0];
  localparam logic [W-1:0] SFR_HI = SFR_END[W-1:0];
  localparam logic [W-1:0] RAM_LO = RAM_BASE[W-1:0];
  localparam logic [W-1:0] RAM_HI = RAM_END[W-1:0];
  localparam logic [W-1:0] ROM_LO = ROM_BASE[W-1:0];
  localparam logic [W-1:0] ROM_HI = ROM_END[W-1:0];
  localparam logic [ADDR_W-1:0] CTL_A = CTL_ADDR[ADDR_W-1:0];

  logic [W-1:0] a_ext;
  logic         hit_sfr, hit_ram, hit_rom;

  assign a_ext   = {1'b0, addr};
  assign hit_sfr = (a_ext >= SFR_LO) && (a_ext < SFR_HI);
  assign hit_ram = (a_ext >= RAM_LO) && (a_ext < RAM_HI);
  assign hit_rom = (a_ext >= ROM_LO) && (a_ext < ROM_HI);

  always_comb begin
    dec.is_ctl = (addr == CTL_A);
    if (dec.is_ctl || hit_sfr) dec.region = RG_SFR;
    else if (hit_ram)          dec.region = RG_RAM;
    else if (hit_rom)          dec.region = RG_ROM;
    else                       dec.region = RG_NONE;
  end

endmodule

// File: rtl/ibiu_ctlreg.sv
module ibiu_ctlreg #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SEL_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bit,
  output logic              slow_q,
  output logic [DATA_W-1:0] rd_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     slow_q <= 1'b0;
    else if (wr_en) slow_q <= wr_bit;
  end

  // only the select position carries state; the rest read as zero
  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == SEL_BIT) begin : g_live
      assign rd_word[b] = slow_q;
    end else begin : g_zero
      assign rd_word[b] = 1'b0;
    end
  end

endmodule

// File: rtl/ibiu_seq.sv
module ibiu_seq #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] len_in,
  output logic             accept,
  output logic             busy,
  output logic             last
);

  typedef enum logic {S_IDLE, S_BUSY} state_e;

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;

  assign accept = (state_q == S_IDLE) && req;
  assign busy   = (state_q == S_BUSY);
  assign last   = busy && (cnt_q == len_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req) begin
          state_q <= S_BUSY;
          cnt_q   <= '0;
          len_q   <= len_in;
        end
        S_BUSY: if (last) state_q <= S_IDLE;
                else      cnt_q   <= cnt_q + CNT_W'(1);
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ibiu_top.sv
module ibiu_top
  import ibiu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FAST_CYC = 2,
  parameter int unsigned SLOW_CYC = 3,
  parameter int unsigned SFR_BASE = 'h0000,
  parameter int unsigned SFR_SIZE = 'h0080,
  parameter int unsigned RAM_BASE = 'h0080,
  parameter int unsigned RAM_SIZE = 'h0F80,
  parameter int unsigned ROM_BASE = 'h8000,
  parameter int unsigned ROM_SIZE = 'h8000,
  parameter int unsigned CTL_ADDR = 'h005F,
  parameter int unsigned SEL_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic [2:0]        bus_sel,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned CNT_W = $clog2(SLOW_CYC + 1);
  localparam logic [CNT_W-1:0] LEN_FAST = CNT_W'(FAST_CYC);
  localparam logic [CNT_W-1:0] LEN_SLOW = CNT_W'(SLOW_CYC);

  decode_t           dec_in;
  logic              accept, busy, last;
  logic              rom_slow;
  logic [DATA_W-1:0] ctl_word;
  logic [CNT_W-1:0]  len_sel;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wbuf_q;
  logic [DATA_W-1:0] rbuf_q;
  logic              we_q;
  logic              ctl_q;
  region_e           region_q;

  logic [DATA_W-1:0] rd_mux;
  logic              ext_cyc;
  logic              ctl_wr;

  ibiu_decode #(
    .ADDR_W  (ADDR_W),
    .SFR_BASE(SFR_BASE), .SFR_SIZE(SFR_SIZE),
    .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE),
    .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE),
    .CTL_ADDR(CTL_ADDR)
  ) u_dec (
    .addr(cpu_addr),
    .dec (dec_in)
  );

  // length is frozen at acceptance; a later select change waits for the next transfer
  assign len_sel = (dec_in.region == RG_ROM && rom_slow) ? LEN_SLOW : LEN_FAST;

  ibiu_seq #(.CNT_W(CNT_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cpu_req),
    .len_in(len_sel),
    .accept(accept),
    .busy  (busy),
    .last  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wbuf_q   <= '0;
      we_q     <= 1'b0;
      ctl_q    <= 1'b0;
      region_q <= RG_NONE;
    end else if (accept) begin
      addr_q   <= cpu_addr;
      wbuf_q   <= cpu_wdata;
      we_q     <= cpu_we;
      ctl_q    <= dec_in.is_ctl;
      region_q <= dec_in.region;
    end
  end

  assign ctl_wr = last && we_q && ctl_q;

  ibiu_ctlreg #(.DATA_W(DATA_W), .SEL_BIT(SEL_BIT)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctl_wr),
    .wr_bit (wbuf_q[SEL_BIT]),
    .slow_q (rom_slow),
    .rd_word(ctl_word)
  );

  always_comb begin
    if (ctl_q)                   rd_mux = ctl_word;
    else if (region_q == RG_NONE) rd_mux = '0;
    else                          rd_mux = bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rbuf_q <= '0;
    else if (last && !we_q)  rbuf_q <= rd_mux;
  end

  assign ext_cyc   = busy && !ctl_q && (region_q != RG_NONE);
  assign bus_sel   = ext_cyc ? region_q : RG_NONE;
  assign bus_we    = ext_cyc && we_q && last;
  assign bus_addr  = addr_q;
  assign bus_wdata = wbuf_q;
  assign cpu_ready = last;
  assign cpu_rdata = (last && !we_q) ? rd_mux : rbuf_q;

endmodule

// File: rtl/ibiu_chk.sv
module ibiu_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              bus_we,
  input logic [2:0]        bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rom_slow
);

  a_r7_we_final: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> cpu_ready);

  a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel));

  a_r7_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel != 3'b000 && !cpu_ready) |=> ($stable(bus_addr) && $stable(bus_wdata)));

  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r9_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> (bus_sel == 3'b000));

  a_r2_two_clk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_sel[1]) || $rose(bus_sel[2])) |-> (!cpu_ready ##1 cpu_ready));

  a_r3_rom_fast: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_sel[0]) && !rom_slow) |-> (!cpu_ready ##1 cpu_ready));

  a_r3_rom_slow: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_sel[0]) && rom_slow) |-> (!cpu_ready ##1 !cpu_ready ##1 cpu_ready));

endmodule

bind ibiu_top ibiu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_ready(cpu_ready),
  .bus_we   (bus_we),
  .bus_sel  (bus_sel),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .rom_slow (rom_slow)
);

// File: tb/tb_ibiu_top.sv
`timescale 1ns/1ps
module tb_ibiu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready;
  logic [7:0]  cpu_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic [2:0]  bus_sel;
  logic [7:0]  bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ibiu_top dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_rdata(bus_rdata)
  );

  // memory model: byte pattern addr^0x5A, indexed by the low address byte
  logic [7:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
  always @(posedge clk) if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
  assign bus_rdata = mem[bus_addr[7:0]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wdata;
    int          lat;
    logic [7:0]  rdata;
    int          nwe;
    logic [2:0]  sel;
  } item_t;
  item_t exp_q[$];
  string tag_q[$];
  int elapsed = 0;
  int we_seen = 0;

  always @(negedge clk) begin
    if (rst_n && exp_q.size() != 0) begin
      elapsed++;
      if (bus_sel != 3'b000)
        chk({tag_q[0], " R7 addr stable"}, 32'(bus_addr), 32'(exp_q[0].addr));
      if (bus_we) begin
        we_seen++;
        chk({tag_q[0], " R7 strobe data"}, 32'(bus_wdata), 32'(exp_q[0].wdata));
      end
      if (cpu_ready) begin
        item_t it;
        string tg;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk({tg, " latency"}, 32'(elapsed), 32'(it.lat + 1));
        chk({tg, " R7 sel"}, 32'(bus_sel), 32'(it.sel));
        chk({tg, " R7 strobes"}, 32'(we_seen), 32'(it.nwe));
        if (!it.we) chk({tg, " R6 rdata"}, 32'(cpu_rdata), 32'(it.rdata));
        elapsed = 0;
        we_seen = 0;
      end
    end
  end

  task automatic xfer(input logic we, input logic [15:0] addr, input logic [7:0] wd,
                      input int lat, input logic [7:0] rd, input int nwe,
                      input logic [2:0] sel, input string tag, input bit scramble);
    item_t it;
    it.we = we; it.addr = addr; it.wdata = wd; it.lat = lat;
    it.rdata = rd; it.nwe = nwe; it.sel = sel;
    @(posedge clk); #1;
    exp_q.push_back(it);
    tag_q.push_back(tag);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    if (scramble) begin
      @(posedge clk); #1;
      cpu_addr  = addr ^ 16'h00F0;
      cpu_wdata = ~wd;
      cpu_we    = ~we;
    end
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    @(posedge clk); #1;
    cpu_req = 1'b0;
    @(negedge clk);
    chk({tag, " R9 ready one clock"}, 32'(cpu_ready), 32'd0);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(cpu_ready), 32'd0);
    chk("R1 we in reset", 32'(bus_we), 32'd0);
    chk("R1 sel in reset", 32'(bus_sel), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R9: no request, nothing starts
    repeat (4) begin
      @(negedge clk);
      chk("R9 idle ready", 32'(cpu_ready), 32'd0);
      chk("R9 idle sel", 32'(bus_sel), 32'd0);
    end

    xfer(0, 16'h005F, 8'h00, 2, 8'h00, 0, 3'b000, "R1 R4 ctl after reset", 0);
    xfer(0, 16'h8012, 8'h00, 2, 8'h48, 0, 3'b001, "R1 R3 rom fast", 0);
    xfer(1, 16'h0123, 8'h3C, 2, 8'h00, 1, 3'b010, "R2 R7 ram write", 0);
    xfer(0, 16'h0123, 8'h00, 2, 8'h3C, 0, 3'b010, "R6 ram readback", 0);
    chk("R6 rdata held", 32'(cpu_rdata), 32'h3C);
    xfer(0, 16'h0010, 8'h00, 2, 8'h4A, 0, 3'b100, "R2 sfr read", 0);

    // select bit to 1, then ROM straight after
    xfer(1, 16'h005F, 8'hFF, 2, 8'h00, 0, 3'b000, "R4 ctl write", 0);
    xfer(0, 16'h8034, 8'h00, 3, 8'h6E, 0, 3'b001, "R3 R5 rom slow", 0);
    xfer(0, 16'h005F, 8'h00, 2, 8'h80, 0, 3'b000, "R4 ctl read", 0);
    xfer(0, 16'h0200, 8'h00, 2, 8'h5A, 0, 3'b010, "R2 ram while slow", 0);

    // R10: fields scrambled after acceptance
    xfer(1, 16'h0130, 8'h77, 2, 8'h00, 1, 3'b010, "R10 scrambled write", 1);
    xfer(0, 16'h0130, 8'h00, 2, 8'h77, 0, 3'b010, "R10 readback", 0);
    xfer(0, 16'h01C0, 8'h00, 2, 8'h9A, 0, 3'b010, "R10 other addr untouched", 0);

    // R8: unmapped region
    xfer(0, 16'h2000, 8'h00, 2, 8'h00, 0, 3'b000, "R8 unmapped read", 0);
    xfer(1, 16'h2144, 8'h99, 2, 8'h00, 0, 3'b000, "R8 unmapped write", 0);
    xfer(0, 16'h0144, 8'h00, 2, 8'h1E, 0, 3'b010, "R8 memory untouched", 0);

    // back to fast
    xfer(1, 16'h005F, 8'h7F, 2, 8'h00, 0, 3'b000, "R4 ctl clear", 0);
    xfer(0, 16'h80AA, 8'h00, 2, 8'hF0, 0, 3'b001, "R3 R5 rom fast again", 0);
    xfer(0, 16'h005F, 8'h00, 2, 8'h00, 0, 3'b000, "R4 ctl read zero", 0);

    chk("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule